// File: doc/BRIEF.md
# Host Cycle Router with Lock Gating

This block sits behind the decoder of a processor's front-side bus requests. Each host request carries two five-bit request-phase codes, a destination select, a read flag, an address and data. The block works out the cycle type from the two codes and steers the request to one of three downstream channels: memory, the hub link or the graphics/PCI port. A branch trace cycle is retired straight back to the processor and goes nowhere. An interrupt acknowledge is always steered to the hub link with a zeroed address.

The block follows the processor lock signal. A bus lock takes hold only once the first read of the locked sequence has been accepted downstream. While the lock holds, requests from the other bus agents pass through an age-ordered gate. A request that needs a host snoop is held for as long as any lock is in force. A coherent memory request is held only while the lock targets memory. Non-coherent memory traffic flows freely. When the lock drops, the held requests leave in the order in which they arrived.

Top module: `host_cycle_router`

## Requirements
- R1: A host request with first code 5'b01000 and second code bits [2:0] equal to 3'b001 is a special cycle. It goes to the hub link with `hub_kind` = 2, whatever bits [4:3] of the second code hold.
- R2: A host request with first code 5'b01000 and second code bits [2:0] equal to 3'b000 is an interrupt acknowledge. It goes to the hub link with `hub_kind` = 1 and `fwd_addr` = 0, whatever the destination select and the address say.
- R3: A host request with first code 5'b01001 is a branch trace cycle. `bt_retire` and `hreq_ready` rise in the same cycle, and no downstream valid is raised.
- R4: Any other host request is an ordinary cycle (`hub_kind` = 0). It is steered by `hreq_dest`: 0 goes to memory, 1 and 3 go to the hub link, 2 goes to graphics/PCI. `hreq_ready` follows the ready of the selected channel.
- R5: `hub_lock` is high exactly when an ordinary cycle goes to the hub link while `cpu_lock` is high. Locked requests to graphics/PCI carry no lock indication and never establish a lock.
- R6: A lock is established at the clock edge that accepts an ordinary read to memory or the hub link while `cpu_lock` is high. Until then, agent traffic is not gated. The lock clears at the first clock edge that samples `cpu_lock` low.
- R7: While a lock established by a memory read is in force, an agent request with `ag_to_mem` and `ag_coherent` both set is held. A non-coherent memory request is granted. Under a lock established by a hub-link read, coherent memory requests are not held.
- R8: While any lock is in force, an agent request with `ag_snoop` set is held, and `agm_snoop` is never seen high on a granted request.
- R9: Among agent requests that may proceed, the one that raised its valid earliest is granted first. Requests that raised valid in the same cycle are ordered by lower index. Held requests are therefore released in arrival order once the lock clears.
- R10: When the hub agent (index `HUB_AG`) has a request accepted with `hub_ag_lock` and `ag_to_mem` set, `lock_err` pulses high for one cycle on the next cycle. The request itself is granted and forwarded as an ordinary unlocked request.
- R11: At most one agent is granted per cycle. `ag_ready` is raised only for an agent whose valid is high, and only while `agm_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_lock | input | 1 | Processor bus lock, active high |
| hreq_valid | input | 1 | Host request valid |
| hreq_ready | output | 1 | Host request accepted |
| hreq_code_a | input | 5 | First request-phase code |
| hreq_code_b | input | 5 | Second request-phase code |
| hreq_dest | input | 2 | Destination select for ordinary cycles |
| hreq_read | input | 1 | Request is a read |
| hreq_addr | input | ADDR_W | Host request address |
| hreq_data | input | DATA_W | Host request data |
| mem_valid | output | 1 | Request to memory |
| mem_ready | input | 1 | Memory accepts |
| hub_valid | output | 1 | Request to the hub link |
| hub_ready | input | 1 | Hub link accepts |
| hub_kind | output | 2 | Cycle type on the hub link |
| hub_lock | output | 1 | Lock indicator in the hub request packet |
| gfx_valid | output | 1 | Request to graphics/PCI |
| gfx_ready | input | 1 | Graphics/PCI accepts |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_data | output | DATA_W | Forwarded data |
| fwd_read | output | 1 | Forwarded read flag |
| bt_retire | output | 1 | Branch trace cycle retired |
| ag_valid | input | N_AG | Agent request valid |
| ag_ready | output | N_AG | Agent request granted |
| ag_coherent | input | N_AG | Agent request is coherent |
| ag_snoop | input | N_AG | Agent request needs a host snoop |
| ag_to_mem | input | N_AG | Agent request targets memory |
| ag_addr | input | N_AG x ADDR_W | Agent request address |
| hub_ag_lock | input | 1 | Hub agent marks its request locked |
| agm_valid | output | 1 | Granted agent request valid |
| agm_ready | input | 1 | Downstream accepts agent request |
| agm_id | output | AG_W | Index of the granted agent |
| agm_addr | output | ADDR_W | Address of the granted agent request |
| agm_coherent | output | 1 | Coherent flag of the granted request |
| agm_snoop | output | 1 | Snoop flag of the granted request |
| agm_to_mem | output | 1 | Memory flag of the granted request |
| lock_err | output | 1 | Unsupported hub-locked memory request seen |

## Verification
The properties take it for granted that an agent holds its valid and fields steady until it is granted. They also assume that `cpu_lock` stays high across a locked sequence and that the request codes are stable while a host request waits. The directed scenarios raise each agent valid once and keep it up until the matching ready has been seen. They change host codes only on idle cycles, and they move `cpu_lock` only between requests. No property therefore depends on input behaviour that the rules forbid.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

  typedef enum logic [1:0] {
    CK_NORMAL  = 2'd0,
    CK_IACK    = 2'd1,
    CK_SPECIAL = 2'd2,
    CK_BTRACE  = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    DST_MEM = 2'd0,
    DST_HUB = 2'd1,
    DST_GFX = 2'd2,
    DST_ALT = 2'd3
  } dest_e;

  localparam logic [4:0] CODE_A_SYS     = 5'b01000;
  localparam logic [4:0] CODE_A_BTRACE  = 5'b01001;
  localparam logic [2:0] CODE_B_SPECIAL = 3'b001;
  localparam logic [2:0] CODE_B_IACK    = 3'b000;

  // Cycle type from the two request-phase codes; upper bits of code b ignored.
  function automatic cyc_kind_e classify_cycle(input logic [4:0] a, input logic [4:0] b);
    cyc_kind_e k;
    k = CK_NORMAL;
    if (a == CODE_A_BTRACE)                             k = CK_BTRACE;
    else if (a == CODE_A_SYS && b[2:0] == CODE_B_SPECIAL) k = CK_SPECIAL;
    else if (a == CODE_A_SYS && b[2:0] == CODE_B_IACK)    k = CK_IACK;
    return k;
  endfunction

  // Final channel: system cycles always to the hub link, spare select to the hub.
  function automatic dest_e steer(input cyc_kind_e k, input dest_e d);
    dest_e r;
    r = d;
    if (k == CK_IACK || k == CK_SPECIAL) r = DST_HUB;
    else if (d == DST_ALT)               r = DST_HUB;
    return r;
  endfunction

  // True when older_agent beats younger_agent in the age order.
  function automatic logic ages_before(input logic trk_j, input logic trk_i,
                                       input logic stored_j_before_i, input logic low_index_j);
    logic r;
    if (trk_j && !trk_i)      r = 1'b1;
    else if (!trk_j && trk_i) r = 1'b0;
    else if (trk_j && trk_i)  r = stored_j_before_i;
    else                      r = low_index_j;
    return r;
  endfunction

endpackage

// File: rtl/hcr_classify.sv
module hcr_classify
  import hcr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              valid,
  input  logic [4:0]        code_a,
  input  logic [4:0]        code_b,
  input  logic [1:0]        dest,
  input  logic              cpu_lock,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_ready,
  input  logic              hub_ready,
  input  logic              gfx_ready,
  output cyc_kind_e         kind,
  output dest_e             route,
  output logic              mem_v,
  output logic              hub_v,
  output logic              gfx_v,
  output logic              retire,
  output logic              ready,
  output logic              accept,
  output logic              hub_lock_bit,
  output logic [ADDR_W-1:0] addr_o
);

  logic forward;
  logic sel_ready;

  always_comb begin
    kind    = classify_cycle(code_a, code_b);
    route   = steer(kind, dest_e'(dest));
    retire  = valid && (kind == CK_BTRACE);
    forward = valid && (kind != CK_BTRACE);
    mem_v   = forward && (route == DST_MEM);
    hub_v   = forward && (route == DST_HUB);
    gfx_v   = forward && (route == DST_GFX);
    unique case (route)
      DST_MEM: sel_ready = mem_ready;
      DST_GFX: sel_ready = gfx_ready;
      default: sel_ready = hub_ready;
    endcase
    ready        = (kind == CK_BTRACE) ? 1'b1 : sel_ready;
    accept       = valid && ready;
    hub_lock_bit = hub_v && cpu_lock && (kind == CK_NORMAL);
    addr_o       = (kind == CK_IACK) ? '0 : addr;
  end

endmodule

// File: rtl/hcr_lock_fsm.sv
module hcr_lock_fsm
  import hcr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cpu_lock,
  input  logic      host_accept,
  input  logic      host_read,
  input  cyc_kind_e kind,
  input  dest_e     route,
  output logic      lock_active,
  output logic      lock_on_mem,
  output logic      set_evt,
  output logic      clr_evt
);

  logic lock_q;
  logic mem_q;

  always_comb begin
    set_evt = !lock_q && cpu_lock && host_accept && host_read &&
              (kind == CK_NORMAL) && (route != DST_GFX);
    clr_evt = lock_q && !cpu_lock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      mem_q  <= 1'b0;
    end else if (clr_evt) begin
      lock_q <= 1'b0;
      mem_q  <= 1'b0;
    end else if (set_evt) begin
      lock_q <= 1'b1;
      mem_q  <= (route == DST_MEM);
    end
  end

  assign lock_active = lock_q;
  assign lock_on_mem = mem_q;

endmodule

// File: rtl/hcr_agent_gate.sv
module hcr_agent_gate
  import hcr_pkg::*;
#(
  parameter int N_AG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_AG-1:0] valid,
  input  logic [N_AG-1:0] coherent,
  input  logic [N_AG-1:0] snoop,
  input  logic [N_AG-1:0] to_mem,
  input  logic            lock_active,
  input  logic            lock_on_mem,
  input  logic            down_ready,
  output logic [N_AG-1:0] blocked,
  output logic [N_AG-1:0] grant,
  output logic [N_AG-1:0] ready
);

  logic [N_AG-1:0] tracked_q;
  logic [N_AG-1:0] arrive;
  logic [N_AG-1:0] eligible;
  logic [N_AG-1:0] before_q [N_AG];  // before_q[j][i]: j arrived ahead of i

  for (genvar i = 0; i < N_AG; i++) begin : g_agent
    logic [N_AG-1:0] beaten_by;

    always_comb begin
      blocked[i]  = lock_active && (snoop[i] || (lock_on_mem && to_mem[i] && coherent[i]));
      eligible[i] = valid[i] && !blocked[i];
      arrive[i]   = valid[i] && !tracked_q[i];
      for (int j = 0; j < N_AG; j++) begin
        beaten_by[j] = (j != i) && eligible[j] &&
                       ages_before(tracked_q[j], tracked_q[i], before_q[j][i], j < i);
      end
      grant[i] = eligible[i] && (beaten_by == '0);
      ready[i] = grant[i] && down_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tracked_q[i] <= 1'b0;
      end else begin
        tracked_q[i] <= valid[i] && !ready[i];
      end
    end

    for (genvar j = 0; j < N_AG; j++) begin : g_pair
      if (j != i) begin : g_ne
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            before_q[j][i] <= 1'b0;
          end else if (arrive[i]) begin
            before_q[j][i] <= tracked_q[j] || (arrive[j] && (j < i));
          end else if (arrive[j]) begin
            before_q[j][i] <= 1'b0;
          end
        end
      end else begin : g_eq
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) before_q[j][i] <= 1'b0;
          else        before_q[j][i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/host_cycle_router.sv
module host_cycle_router
  import hcr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int N_AG   = 3,
  parameter int HUB_AG = 0,
  localparam int AG_W  = (N_AG > 1) ? $clog2(N_AG) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_lock,
  input  logic                       hreq_valid,
  output logic                       hreq_ready,
  input  logic [4:0]                 hreq_code_a,
  input  logic [4:0]                 hreq_code_b,
  input  logic [1:0]                 hreq_dest,
  input  logic                       hreq_read,
  input  logic [ADDR_W-1:0]          hreq_addr,
  input  logic [DATA_W-1:0]          hreq_data,
  output logic                       mem_valid,
  input  logic                       mem_ready,
  output logic                       hub_valid,
  input  logic                       hub_ready,
  output logic [1:0]                 hub_kind,
  output logic                       hub_lock,
  output logic                       gfx_valid,
  input  logic                       gfx_ready,
  output logic [ADDR_W-1:0]          fwd_addr,
  output logic [DATA_W-1:0]          fwd_data,
  output logic                       fwd_read,
  output logic                       bt_retire,
  input  logic [N_AG-1:0]            ag_valid,
  output logic [N_AG-1:0]            ag_ready,
  input  logic [N_AG-1:0]            ag_coherent,
  input  logic [N_AG-1:0]            ag_snoop,
  input  logic [N_AG-1:0]            ag_to_mem,
  input  logic [N_AG-1:0][ADDR_W-1:0] ag_addr,
  input  logic                       hub_ag_lock,
  output logic                       agm_valid,
  input  logic                       agm_ready,
  output logic [AG_W-1:0]            agm_id,
  output logic [ADDR_W-1:0]          agm_addr,
  output logic                       agm_coherent,
  output logic                       agm_snoop,
  output logic                       agm_to_mem,
  output logic                       lock_err
);

  cyc_kind_e       kind;
  dest_e           route;
  logic            host_accept;
  logic            lock_active;
  logic            lock_on_mem;
  logic            lock_set_evt;
  logic            lock_clr_evt;
  logic [N_AG-1:0] ag_blocked;
  logic [N_AG-1:0] ag_grant;
  logic            unsup_lock_evt;
  logic            err_q;

  hcr_classify #(.ADDR_W(ADDR_W)) u_classify (
    .valid        (hreq_valid),
    .code_a       (hreq_code_a),
    .code_b       (hreq_code_b),
    .dest         (hreq_dest),
    .cpu_lock     (cpu_lock),
    .addr         (hreq_addr),
    .mem_ready    (mem_ready),
    .hub_ready    (hub_ready),
    .gfx_ready    (gfx_ready),
    .kind         (kind),
    .route        (route),
    .mem_v        (mem_valid),
    .hub_v        (hub_valid),
    .gfx_v        (gfx_valid),
    .retire       (bt_retire),
    .ready        (hreq_ready),
    .accept       (host_accept),
    .hub_lock_bit (hub_lock),
    .addr_o       (fwd_addr)
  );

  assign hub_kind = kind;
  assign fwd_data = hreq_data;
  assign fwd_read = hreq_read;

  hcr_lock_fsm u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_lock    (cpu_lock),
    .host_accept (host_accept),
    .host_read   (hreq_read),
    .kind        (kind),
    .route       (route),
    .lock_active (lock_active),
    .lock_on_mem (lock_on_mem),
    .set_evt     (lock_set_evt),
    .clr_evt     (lock_clr_evt)
  );

  hcr_agent_gate #(.N_AG(N_AG)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (ag_valid),
    .coherent    (ag_coherent),
    .snoop       (ag_snoop),
    .to_mem      (ag_to_mem),
    .lock_active (lock_active),
    .lock_on_mem (lock_on_mem),
    .down_ready  (agm_ready),
    .blocked     (ag_blocked),
    .grant       (ag_grant),
    .ready       (ag_ready)
  );

  always_comb begin
    agm_valid    = |ag_grant;
    agm_id       = '0;
    agm_addr     = '0;
    agm_coherent = 1'b0;
    agm_snoop    = 1'b0;
    agm_to_mem   = 1'b0;
    for (int i = 0; i < N_AG; i++) begin
      if (ag_grant[i]) begin
        agm_id       = AG_W'(i);
        agm_addr     = ag_addr[i];
        agm_coherent = ag_coherent[i];
        agm_snoop    = ag_snoop[i];
        agm_to_mem   = ag_to_mem[i];
      end
    end
  end

  assign unsup_lock_evt = ag_ready[HUB_AG] && hub_ag_lock && ag_to_mem[HUB_AG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= unsup_lock_evt;
  end

  assign lock_err = err_q;

endmodule

// File: rtl/hcr_checker.sv
module hcr_checker #(
  parameter int ADDR_W = 32,
  parameter int N_AG   = 3,
  parameter int HUB_AG = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_lock,
  input logic              hreq_valid,
  input logic              hreq_ready,
  input logic              hreq_read,
  input logic [4:0]        hreq_code_a,
  input logic [4:0]        hreq_code_b,
  input logic              mem_valid,
  input logic              hub_valid,
  input logic              gfx_valid,
  input logic [1:0]        hub_kind,
  input logic              hub_lock,
  input logic              bt_retire,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic              lock_active,
  input logic [N_AG-1:0]   ag_valid,
  input logic [N_AG-1:0]   ag_ready,
  input logic [N_AG-1:0]   ag_to_mem,
  input logic              hub_ag_lock,
  input logic              agm_valid,
  input logic              agm_snoop,
  input logic              lock_err
);

  p_special_hub_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq_valid && hreq_code_a == 5'b01000 && hreq_code_b[2:0] == 3'b001)
      |-> (hub_valid && hub_kind == 2'd2));

  p_iack_hub_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq_valid && hreq_code_a == 5'b01000 && hreq_code_b[2:0] == 3'b000)
      |-> (hub_valid && !gfx_valid && !mem_valid && fwd_addr == '0));

  p_btrace_retire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq_valid && hreq_code_a == 5'b01001)
      |-> (bt_retire && hreq_ready && !mem_valid && !hub_valid && !gfx_valid));

  p_hub_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hub_lock |-> (hub_valid && cpu_lock));

  p_lock_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_lock |=> !lock_active);

  p_lock_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_active) |-> $past(cpu_lock && hreq_valid && hreq_ready && hreq_read));

  p_snoop_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_active && agm_valid) |-> !agm_snoop);

  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |-> $past(ag_ready[HUB_AG] && hub_ag_lock && ag_to_mem[HUB_AG]));

  p_one_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ag_ready));

  p_ready_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ag_ready & ~ag_valid) == '0);

endmodule

bind host_cycle_router hcr_checker #(.ADDR_W(ADDR_W), .N_AG(N_AG), .HUB_AG(HUB_AG)) u_chk (.*);

// File: tb/host_cycle_router_test.sv
module host_cycle_router_test;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int N_AG   = 3;
  localparam int AG_W   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_lock = 1'b0;
  logic hreq_valid = 1'b0, hreq_ready, hreq_read = 1'b0;
  logic [4:0] hreq_code_a = '0, hreq_code_b = '0;
  logic [1:0] hreq_dest = '0;
  logic [ADDR_W-1:0] hreq_addr = '0;
  logic [DATA_W-1:0] hreq_data = '0;
  logic mem_valid, hub_valid, gfx_valid, hub_lock, bt_retire, fwd_read;
  logic mem_ready = 1'b1, hub_ready = 1'b1, gfx_ready = 1'b1;
  logic [1:0] hub_kind;
  logic [ADDR_W-1:0] fwd_addr;
  logic [DATA_W-1:0] fwd_data;
  logic [N_AG-1:0] ag_valid = '0, ag_ready, ag_coherent = '0, ag_snoop = '0, ag_to_mem = '0;
  logic [N_AG-1:0][ADDR_W-1:0] ag_addr = '0;
  logic hub_ag_lock = 1'b0;
  logic agm_valid, agm_ready = 1'b1, agm_coherent, agm_snoop, agm_to_mem, lock_err;
  logic [AG_W-1:0] agm_id;
  logic [ADDR_W-1:0] agm_addr;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  host_cycle_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_AG(N_AG), .HUB_AG(0)) uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_idle();
    hreq_valid = 1'b0; hreq_code_a = 5'b00110; hreq_code_b = '0; hreq_dest = '0; hreq_read = 1'b0;
  endtask

  task automatic host_req(input logic [4:0] a, input logic [4:0] b, input logic [1:0] d,
                          input logic rd, input logic [ADDR_W-1:0] ad);
    hreq_valid = 1'b1; hreq_code_a = a; hreq_code_b = b; hreq_dest = d; hreq_read = rd; hreq_addr = ad;
  endtask

  task automatic agent(input int i, input logic v, input logic coh, input logic snp, input logic mem);
    ag_valid[i] = v; ag_coherent[i] = coh; ag_snoop[i] = snp; ag_to_mem[i] = mem;
    ag_addr[i] = 32'h1000 + i;
  endtask

  function automatic logic [2:0] dvals();
    return {mem_valid, hub_valid, gfx_valid};
  endfunction

  task automatic t_reset();
    #5;
    chk(dvals() == 3'b000 && ag_ready == '0 && lock_err == 1'b0 && agm_valid == 1'b0,
        "reset R11", {dvals(), ag_ready}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_special_r1();
    for (int u = 0; u < 4; u++) begin
      @(negedge clk); host_req(5'b01000, {u[1:0], 3'b001}, 2'd2, 1'b0, 32'h55);
      #5 chk(dvals() == 3'b010 && hub_kind == 2'd2, "R1 special to hub", {dvals(), hub_kind}, {3'b010, 2'd2});
    end
    @(negedge clk); host_req(5'b01000, 5'b00011, 2'd1, 1'b0, 32'h55);
    #5 chk(hub_kind == 2'd0, "R1 near-miss code is ordinary", hub_kind, 0);
    @(negedge clk); host_idle();
  endtask

  task automatic t_iack_r2();
    @(negedge clk); host_req(5'b01000, 5'b11000, 2'd2, 1'b1, 32'hDEAD_BEEF);
    #5 chk(dvals() == 3'b010 && hub_kind == 2'd1 && fwd_addr == '0, "R2 iack to hub, addr zero",
           {dvals(), hub_kind, fwd_addr}, {3'b010, 2'd1, 32'h0});
    @(negedge clk); host_idle();
  endtask

  task automatic t_btrace_r3();
    @(negedge clk); host_req(5'b01001, 5'b00000, 2'd0, 1'b0, 32'h77); mem_ready = 1'b0;
    #5 chk(bt_retire && hreq_ready && dvals() == 3'b000, "R3 branch trace retired",
           {bt_retire, hreq_ready, dvals()}, {2'b11, 3'b000});
    @(negedge clk); host_idle(); mem_ready = 1'b1;
  endtask

  task automatic t_route_r4();
    logic [2:0] exp_v [4] = '{3'b100, 3'b010, 3'b001, 3'b010};
    for (int d = 0; d < 4; d++) begin
      @(negedge clk); host_req(5'b00110, 5'b00010, d[1:0], 1'b0, 32'h40 + d);
      #5 chk(dvals() == exp_v[d] && fwd_addr == 32'h40 + d && !bt_retire, "R4 destination select",
             dvals(), exp_v[d]);
    end
    @(negedge clk); host_req(5'b00110, 5'b00010, 2'd0, 1'b0, 32'h40); mem_ready = 1'b0;
    #5 chk(hreq_ready == 1'b0, "R4 ready follows memory", hreq_ready, 0);
    @(negedge clk); host_idle(); mem_ready = 1'b1;
  endtask

  task automatic t_hub_lock_r5();
    @(negedge clk); cpu_lock = 1'b1; host_req(5'b00110, 5'b0, 2'd1, 1'b0, 32'h10);
    #5 chk(hub_lock == 1'b1, "R5 hub packet lock bit", hub_lock, 1);
    @(negedge clk); host_req(5'b00110, 5'b0, 2'd2, 1'b1, 32'h10);
    #5 chk(gfx_valid && !hub_lock, "R5 gfx locked forwarded plain", {gfx_valid, hub_lock}, 2'b10);
    @(negedge clk); host_idle(); agent(1, 1, 0, 1, 0);
    #5 chk(ag_ready == 3'b010, "R5 gfx locked read sets no lock", ag_ready, 3'b010);
    @(negedge clk); agent(1, 0, 0, 0, 0); cpu_lock = 1'b0;
    @(negedge clk); host_req(5'b00110, 5'b0, 2'd1, 1'b0, 32'h10);
    #5 chk(hub_lock == 1'b0, "R5 no lock bit when unlocked", hub_lock, 0);
    @(negedge clk); host_idle();
  endtask

  task automatic t_mem_lock_r6_r7_r8_r9();
    @(negedge clk); cpu_lock = 1'b1; agent(1, 1, 1, 0, 1);
    #5 chk(ag_ready == 3'b010, "R6 no gating before first locked read", ag_ready, 3'b010);
    @(negedge clk); agent(1, 0, 0, 0, 0); host_req(5'b00110, 5'b0, 2'd0, 1'b1, 32'h80);
    @(negedge clk); host_idle(); agent(2, 1, 0, 1, 0);
    #5 chk(ag_ready == 3'b000, "R8 snoop request held under lock", ag_ready, 0);
    @(negedge clk); agent(1, 1, 1, 0, 1); agent(0, 1, 0, 0, 1);
    #5 chk(ag_ready == 3'b001 && agm_id == 0, "R7 non-coherent passes, coherent held",
           {ag_ready, agm_id}, {3'b001, 2'd0});
    @(negedge clk); agent(0, 0, 0, 0, 0); cpu_lock = 1'b0;
    #5 chk(ag_ready == 3'b000, "R6 lock still in force before edge", ag_ready, 0);
    @(negedge clk);
    #5 chk(ag_ready == 3'b100 && agm_snoop == 1'b1, "R9 oldest held released first",
           ag_ready, 3'b100);
    @(negedge clk); agent(2, 0, 0, 0, 0);
    #5 chk(ag_ready == 3'b010 && agm_addr == 32'h1001, "R9 next held released", ag_ready, 3'b010);
    @(negedge clk); agent(1, 0, 0, 0, 0);
  endtask

  task automatic t_hub_lock_gate_r7();
    @(negedge clk); cpu_lock = 1'b1; host_req(5'b00110, 5'b0, 2'd1, 1'b1, 32'h90);
    @(negedge clk); host_idle(); agent(2, 1, 1, 0, 1); agent(1, 1, 0, 1, 1);
    #5 chk(ag_ready == 3'b100, "R7 coherent memory passes under hub lock", ag_ready, 3'b100);
    @(negedge clk); agent(2, 0, 0, 0, 0);
    #5 chk(ag_ready == 3'b000, "R8 snoop held under hub lock", ag_ready, 0);
    @(negedge clk); cpu_lock = 1'b0;
    @(negedge clk);
    #5 chk(ag_ready == 3'b010, "R8 snoop released after lock", ag_ready, 3'b010);
    @(negedge clk); agent(1, 0, 0, 0, 0);
  endtask

  task automatic t_err_r10();
    @(negedge clk); hub_ag_lock = 1'b1; agent(0, 1, 1, 0, 1);
    #5 chk(ag_ready == 3'b001 && lock_err == 1'b0, "R10 hub locked mem request granted",
           {ag_ready, lock_err}, {3'b001, 1'b0});
    @(negedge clk); hub_ag_lock = 1'b0; agent(0, 0, 0, 0, 0);
    #5 chk(lock_err == 1'b1, "R10 error pulse", lock_err, 1);
    @(negedge clk);
    #5 chk(lock_err == 1'b0, "R10 error is one cycle", lock_err, 0);
  endtask

  task automatic t_backpressure_r11();
    @(negedge clk); agm_ready = 1'b0; agent(0, 1, 0, 0, 1); agent(2, 1, 0, 0, 1);
    #5 chk(ag_ready == '0 && agm_valid && agm_id == 0, "R11 no ready without downstream ready",
           {ag_ready, agm_valid}, {3'b000, 1'b1});
    @(negedge clk); agm_ready = 1'b1;
    #5 chk(ag_ready == 3'b001, "R11 single grant, same-cycle low index first", ag_ready, 3'b001);
    @(negedge clk); agent(0, 0, 0, 0, 0);
    #5 chk(ag_ready == 3'b100, "R11 remaining request granted", ag_ready, 3'b100);
    @(negedge clk); agent(2, 0, 0, 0, 0);
  endtask

  initial begin
    host_idle();
    t_reset();
    t_special_r1();
    t_iack_r2();
    t_btrace_r3();
    t_route_r4();
    t_hub_lock_r5();
    t_mem_lock_r6_r7_r8_r9();
    t_hub_lock_gate_r7();
    t_err_r10();
    t_backpressure_r11();
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule